// File: doc/BRIEF.md
# Fixed-Frequency Chopper Current Regulator for One H-Bridge Phase

This block regulates the current in one winding of a bipolar motor by chopping its H-bridge at a fixed rate. Every PWM period opens with the bridge driving current in the commanded polarity. A comparator from the analog sense path reports when the winding current is above the programmed limit. That comparator is ignored during a blanking window after switch-on, and a trip only counts once it has been held for a filter time. After a trip the bridge recirculates for the rest of the period using slow, fast or mixed decay. In the automatic mode the decay pattern is chosen from whether the next step's current magnitude is above or below the present one.

The current limit, polarity, decay mode and slew-rate code are captured only at period boundaries. The captured limit goes to the sense DAC. The four switch enables pass through a dead-band stage. Whenever the wanted pattern changes, that stage holds back every switch that is not common to the old and new patterns for a dead time chosen by the slew-rate code. The internal on/off state of the chopper is also available as a digital PWM output.

Top module: `pwm_chop_reg`

## Requirements
- R1: While reset is asserted, all four switch enables, `pwm_out` and `lim_out` are 0. The first period starts on the first clock edge after reset is released, so `pwm_out` is 1 one cycle after release.
- R2: A period lasts PERIOD cycles and always starts in the on state, with `pwm_out` = 1. With polarity 1 the on pattern is `hs_a`+`ls_b`; with polarity 0 it is `hs_b`+`ls_a`. `pwm_out` is 1 exactly while the chopper is in the on state.
- R3: `cmp_over` is ignored during the first BLANK cycles of a period. A comparator that is high only during that window leaves the bridge on for the whole period.
- R4: A trip needs FILT consecutive qualified high samples of `cmp_over`. With the comparator held high, `pwm_out` stays high for BLANK+FILT cycles per period. A run that is shorter than FILT never trips.
- R5: If no trip occurs, the bridge stays in its on pattern for the whole period, with no decay phase.
- R6: Slow decay enables `ls_a`+`ls_b`. Fast decay enables the diagonal opposite to the on pattern. Either pattern is held until the period ends.
- R7: Mixed decay runs fast decay for (PERIOD-1-c) >> MIX_SHIFT cycles, where c is the period cycle index at the trip, and then runs slow decay. If that length is 0, slow decay starts at once.
- R8: `mode_in` codes are 0 slow, 1 fast, 2 mixed, 3 automatic. In automatic mode, `next_in` >= `lim_in` selects slow decay. A smaller `next_in` selects fast decay if `amix_in` = 0, or mixed decay if `amix_in` = 1.
- R9: `lim_in`, `pol_in`, `mode_in`, `amix_in`, `next_in` and `sr_in` are sampled only at the period boundary. `lim_out` shows the captured limit and changes only when a period starts.
- R10: The switch outputs follow the state with one cycle of latency. When the wanted pattern changes, only the switches common to both patterns stay on for DT_BASE << sr cycles, where sr is the captured slew code. The new pattern appears after that.
- R11: The two switches of one leg are never on together, and the two high sides are never on together.
- R12: A polarity change across a boundary with no trip gives an all-off gap of the dead-time length before the new diagonal is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal chopper clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_over | input | 1 | Current above limit, from the sense comparator |
| lim_in | input | LW | Current limit for the next period |
| next_in | input | LW | Current magnitude of the following step |
| pol_in | input | 1 | Drive polarity for the next period |
| mode_in | input | 2 | Decay mode code |
| amix_in | input | 1 | Automatic mode on falling current: 0 fast, 1 mixed |
| sr_in | input | 2 | Slew-rate code that selects the dead time |
| hs_a | output | 1 | High-side enable, leg A |
| ls_a | output | 1 | Low-side enable, leg A |
| hs_b | output | 1 | High-side enable, leg B |
| ls_b | output | 1 | Low-side enable, leg B |
| pwm_out | output | 1 | Digital copy of the chopper on state |
| lim_out | output | LW | Limit captured for the current period |

## Verification
A corrupted period counter, or a filter count that is off by one, moves the falling edge of `pwm_out` within the same period and changes the on-time count in every later period. A wrong captured decay choice or mixed-phase length shows up as the wrong diagonal or the wrong fast-decay span on the switch enables, one cycle after the trip. Dead-band faults show up within a few cycles of any pattern change: the all-off or common-switch gap has the wrong length, or two switches of one leg overlap. A cycle-by-cycle reference model therefore exposes each of these within one period.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ON   = 2'd1,
    ST_FAST = 2'd2,
    ST_SLOW = 2'd3
  } chop_st_t;

  typedef enum logic [1:0] {
    DK_SLOW = 2'd0,
    DK_FAST = 2'd1,
    DK_MIX  = 2'd2
  } decay_t;

  // switch vector bit order: {hs_b, ls_b, hs_a, ls_a}
  localparam logic [3:0] PAT_DIAG_P = 4'b0110; // hs_a + ls_b
  localparam logic [3:0] PAT_DIAG_N = 4'b1001; // hs_b + ls_a
  localparam logic [3:0] PAT_LOWS   = 4'b0101; // ls_a + ls_b

  function automatic logic [3:0] sw_pattern(input chop_st_t st, input logic pol);
    logic [3:0] p;
    case (st)
      ST_ON:   p = pol ? PAT_DIAG_P : PAT_DIAG_N;
      ST_FAST: p = pol ? PAT_DIAG_N : PAT_DIAG_P;
      ST_SLOW: p = PAT_LOWS;
      default: p = 4'b0000;
    endcase
    return p;
  endfunction

  function automatic decay_t pick_decay(input logic [1:0] mode, input logic amix,
                                        input logic [7:0] nxt, input logic [7:0] cur);
    decay_t d;
    case (mode)
      2'd0:    d = DK_SLOW;
      2'd1:    d = DK_FAST;
      2'd2:    d = DK_MIX;
      default: d = (nxt >= cur) ? DK_SLOW : (amix ? DK_MIX : DK_FAST);
    endcase
    return d;
  endfunction

endpackage

// File: rtl/chop_qual.sv
module chop_qual #(
  parameter int BLANK = 8,
  parameter int FILT  = 3,
  parameter int CW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on_phase,
  input  logic          clr,
  input  logic [CW-1:0] cnt,
  input  logic          cmp_in,
  output logic          trip
);
  localparam int FW = $clog2(FILT + 1);

  logic [FW-1:0] run_q, run_d;
  logic          qual;

  always_comb begin
    qual = on_phase && (cnt >= CW'(BLANK)) && cmp_in;
    trip = qual && (run_q == FW'(FILT - 1));
    if (clr || !qual || trip) run_d = '0;
    else                      run_d = run_q + FW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end
endmodule

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int PERIOD    = 64,
  parameter int MIX_SHIFT = 2,
  parameter int LW        = 5,
  parameter int CW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trip,
  input  logic [LW-1:0] lim_in,
  input  logic [LW-1:0] next_in,
  input  logic          pol_in,
  input  logic [1:0]    mode_in,
  input  logic          amix_in,
  input  logic [1:0]    sr_in,
  output chop_st_t      st,
  output logic          pol,
  output logic [LW-1:0] lim,
  output logic [1:0]    sr,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  chop_st_t      st_q, st_d;
  decay_t        dk_q, dk_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] ml_q, ml_d;
  logic [CW-1:0] rem, mlen;
  logic          pol_q;
  logic [LW-1:0] lim_q;
  logic [1:0]    sr_q;
  logic          ld_en;

  always_comb begin
    ld_en = (cnt_q == CW'(PERIOD - 1));
    rem   = CW'(PERIOD - 1) - cnt_q;
    mlen  = rem >> MIX_SHIFT;
    st_d  = st_q;
    ml_d  = ml_q;
    dk_d  = dk_q;
    cnt_d = cnt_q + CW'(1);
    if (ld_en) begin
      cnt_d = '0;
      st_d  = ST_ON;
      ml_d  = '0;
      dk_d  = pick_decay(mode_in, amix_in, 8'(next_in), 8'(lim_in));
    end else begin
      case (st_q)
        ST_ON: if (trip) begin
          case (dk_q)
            DK_SLOW: st_d = ST_SLOW;
            DK_FAST: st_d = ST_FAST;
            default: begin
              if (mlen == '0) st_d = ST_SLOW;
              else begin
                st_d = ST_FAST;
                ml_d = mlen - CW'(1);
              end
            end
          endcase
        end
        ST_FAST: if (dk_q == DK_MIX) begin
          if (ml_q == '0) st_d = ST_SLOW;
          else            ml_d = ml_q - CW'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(PERIOD - 1);
      st_q  <= ST_OFF;
      ml_q  <= '0;
      dk_q  <= DK_SLOW;
    end else begin
      cnt_q <= cnt_d;
      st_q  <= st_d;
      ml_q  <= ml_d;
      dk_q  <= dk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= 1'b0;
      lim_q <= '0;
      sr_q  <= '0;
    end else if (ld_en) begin
      pol_q <= pol_in;
      lim_q <= lim_in;
      sr_q  <= sr_in;
    end
  end

  assign st   = st_q;
  assign pol  = pol_q;
  assign lim  = lim_q;
  assign sr   = sr_q;
  assign cnt  = cnt_q;
  assign wrap = ld_en;
endmodule

// File: rtl/chop_deadband.sv
module chop_deadband #(
  parameter int DT_BASE = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] tgt,
  input  logic [1:0] sr,
  output logic [3:0] sw
);
  localparam int DTW = $clog2(DT_BASE * 8) + 1;

  logic [3:0]     goal_q, goal_d, sw_q, sw_d;
  logic [DTW-1:0] dtc_q, dtc_d, dt_len;

  always_comb begin
    dt_len = DTW'(DT_BASE) << sr;
    goal_d = goal_q;
    sw_d   = sw_q;
    dtc_d  = dtc_q;
    if (tgt != goal_q) begin
      goal_d = tgt;
      dtc_d  = dt_len - DTW'(1);
      for (int i = 0; i < 4; i++) sw_d[i] = sw_q[i] & tgt[i];
    end else if (dtc_q != '0) begin
      dtc_d = dtc_q - DTW'(1);
    end else begin
      sw_d = goal_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      goal_q <= '0;
      sw_q   <= '0;
      dtc_q  <= '0;
    end else begin
      goal_q <= goal_d;
      sw_q   <= sw_d;
      dtc_q  <= dtc_d;
    end
  end

  assign sw = sw_q;
endmodule

// File: rtl/pwm_chop_reg.sv
module pwm_chop_reg
  import chop_pkg::*;
#(
  parameter int PERIOD    = 64,
  parameter int BLANK     = 8,
  parameter int FILT      = 3,
  parameter int MIX_SHIFT = 2,
  parameter int DT_BASE   = 1,
  parameter int LW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_over,
  input  logic [LW-1:0] lim_in,
  input  logic [LW-1:0] next_in,
  input  logic          pol_in,
  input  logic [1:0]    mode_in,
  input  logic          amix_in,
  input  logic [1:0]    sr_in,
  output logic          hs_a,
  output logic          ls_a,
  output logic          hs_b,
  output logic          ls_b,
  output logic          pwm_out,
  output logic [LW-1:0] lim_out
);
  localparam int CW = $clog2(PERIOD);

  chop_st_t      st;
  logic          pol, wrap, trip;
  logic [LW-1:0] lim;
  logic [1:0]    sr;
  logic [CW-1:0] cnt;
  logic [3:0]    tgt, sw;

  chop_seq #(.PERIOD(PERIOD), .MIX_SHIFT(MIX_SHIFT), .LW(LW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .trip(trip), .lim_in(lim_in), .next_in(next_in),
    .pol_in(pol_in), .mode_in(mode_in), .amix_in(amix_in), .sr_in(sr_in),
    .st(st), .pol(pol), .lim(lim), .sr(sr), .cnt(cnt), .wrap(wrap)
  );

  chop_qual #(.BLANK(BLANK), .FILT(FILT), .CW(CW)) u_qual (
    .clk(clk), .rst_n(rst_n), .on_phase(st == ST_ON), .clr(wrap),
    .cnt(cnt), .cmp_in(cmp_over), .trip(trip)
  );

  assign tgt = sw_pattern(st, pol);

  chop_deadband #(.DT_BASE(DT_BASE)) u_db (
    .clk(clk), .rst_n(rst_n), .tgt(tgt), .sr(sr), .sw(sw)
  );

  assign ls_a    = sw[0];
  assign hs_a    = sw[1];
  assign ls_b    = sw[2];
  assign hs_b    = sw[3];
  assign pwm_out = (st == ST_ON);
  assign lim_out = lim;
endmodule

// File: rtl/pwm_chop_chk.sv
module pwm_chop_chk #(
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hs_a,
  input logic          ls_a,
  input logic          hs_b,
  input logic          ls_b,
  input logic          pwm_out,
  input logic [LW-1:0] lim_out
);
  // R11
  leg_a_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(hs_a && ls_a));
  // R11
  leg_b_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(hs_b && ls_b));
  // R11
  hs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n) !(hs_a && hs_b));
  // R10
  hs_a_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(hs_a) |-> !$past(ls_a));
  // R10
  ls_a_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ls_a) |-> !$past(hs_a));
  // R9
  lim_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(lim_out) |-> pwm_out);
endmodule

bind pwm_chop_reg pwm_chop_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b),
  .pwm_out(pwm_out), .lim_out(lim_out)
);

// File: tb/pwm_chop_reg_test.sv
module pwm_chop_reg_test;
  localparam int P = 64, B = 8, F = 3, SH = 2, DTB = 1, LW = 5;

  logic clk = 0, rst_n = 0, cmp_over = 0, pol_in = 1, amix_in = 0;
  logic [LW-1:0] lim_in = 5'd10, next_in = 5'd10;
  logic [1:0] mode_in = 0, sr_in = 0;
  logic hs_a, ls_a, hs_b, ls_b, pwm_out;
  logic [LW-1:0] lim_out;

  int checks = 0, fails = 0, cyc = 0, cmp_kind = 0;
  // reference model state
  int m_cnt, m_ph, m_run, m_fl, m_lim, m_pol, m_eff, m_sr, m_goal, m_sw, m_gap;
  int c_on, c_fast, c_slow, c_zero, c_pwm, c_lsb;

  always #4 clk = ~clk;

  pwm_chop_reg #(.PERIOD(P), .BLANK(B), .FILT(F), .MIX_SHIFT(SH), .DT_BASE(DTB), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_over(cmp_over), .lim_in(lim_in), .next_in(next_in),
    .pol_in(pol_in), .mode_in(mode_in), .amix_in(amix_in), .sr_in(sr_in),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b), .pwm_out(pwm_out), .lim_out(lim_out));

  function automatic int pat(int ph, int pl);
    if (ph == 1) return pl ? 6 : 9;
    if (ph == 2) return pl ? 9 : 6;
    if (ph == 3) return 5;
    return 0;
  endfunction

  // phases: 0 off, 1 on, 2 fast, 3 slow; eff: 0 slow, 1 fast, 2 mixed
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = P - 1; m_ph = 0; m_run = 0; m_fl = 0; m_lim = 0; m_pol = 0;
      m_eff = 0; m_sr = 0; m_goal = 0; m_sw = 0; m_gap = 0;
    end else begin
      int t, q, trip, rem, len;
      t = pat(m_ph, m_pol);
      if (t != m_goal) begin m_goal = t; m_sw = m_sw & t; m_gap = (DTB << m_sr) - 1; end
      else if (m_gap > 0) m_gap--;
      else m_sw = m_goal;
      q = (m_ph == 1 && m_cnt >= B && cmp_over) ? 1 : 0;
      trip = (q && m_run == F - 1) ? 1 : 0;
      m_run = (m_cnt == P - 1 || !q || trip) ? 0 : m_run + 1;
      if (m_cnt == P - 1) begin
        m_cnt = 0; m_ph = 1; m_lim = lim_in; m_pol = pol_in; m_sr = sr_in;
        if (mode_in == 3) m_eff = (next_in >= lim_in) ? 0 : (amix_in ? 2 : 1);
        else m_eff = mode_in;
      end else begin
        rem = P - 1 - m_cnt;
        m_cnt++;
        if (m_ph == 1 && trip) begin
          if (m_eff == 0) m_ph = 3;
          else if (m_eff == 1) m_ph = 2;
          else begin
            len = rem >> SH;
            if (len == 0) m_ph = 3; else begin m_ph = 2; m_fl = len; end
          end
        end else if (m_ph == 2 && m_eff == 2) begin
          m_fl--;
          if (m_fl == 0) m_ph = 3;
        end
      end
    end
  end

  always @(negedge clk) begin
    case (cmp_kind)
      0: cmp_over = 0;
      1: cmp_over = 1;
      2: cmp_over = (m_cnt < B);
      default: cmp_over = (m_cnt >= B) && (((m_cnt - B) % F) != F - 1);
    endcase
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && cyc > 0) begin
    checks++;
    if (pwm_out !== (m_ph == 1)) begin fails++; $display("FAIL R2 pwm_out act=%0b exp=%0b", pwm_out, m_ph == 1); end
    checks++;
    if ({hs_b, ls_b, hs_a, ls_a} !== 4'(m_sw)) begin
      fails++; $display("FAIL R10 switches act=%b exp=%b", {hs_b, ls_b, hs_a, ls_a}, 4'(m_sw));
    end
    checks++;
    if (lim_out !== LW'(m_lim)) begin fails++; $display("FAIL R9 lim_out act=%0d exp=%0d", lim_out, m_lim); end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin fails++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp); end
  endtask

  task automatic measure(int pl);
    c_on = 0; c_fast = 0; c_slow = 0; c_zero = 0; c_pwm = 0; c_lsb = 0;
    repeat (2 * P) @(negedge clk);
    while (m_cnt != 0) @(negedge clk);
    for (int i = 0; i < P; i++) begin
      logic [3:0] o;
      o = {hs_b, ls_b, hs_a, ls_a};
      if (o == (pl ? 4'b0110 : 4'b1001)) c_on++;
      if (o == (pl ? 4'b1001 : 4'b0110)) c_fast++;
      if (o == 4'b0101) c_slow++;
      if (o == 4'b0000) c_zero++;
      if (o == 4'b0100) c_lsb++;
      if (pwm_out) c_pwm++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset outputs", int'({hs_a, ls_a, hs_b, ls_b, pwm_out}), 0);
    chk("R1 reset lim_out", int'(lim_out), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 first period on", int'(pwm_out), 1);

    // slow decay, comparator always high
    cmp_kind = 1; mode_in = 0; measure(1);
    chk("R4 on time", c_pwm, B + F);
    chk("R6 slow span", c_slow, P - B - F - 1);
    chk("R2 on pattern pol1", c_on, B + F - 1);

    mode_in = 1; measure(1);
    chk("R6 fast span", c_fast, P - B - F - 1);

    mode_in = 2; measure(1);
    chk("R7 mixed fast span", c_fast, ((P - B - F) >> SH) - 1);
    chk("R7 mixed slow span", c_slow, P - B - F - ((P - B - F) >> SH) - 1);

    mode_in = 0; cmp_kind = 2; measure(1);
    chk("R3 blank ignored", c_pwm, P);
    chk("R5 no decay", c_on, P);

    cmp_kind = 3; measure(1);
    chk("R4 short runs ignored", c_pwm, P);

    cmp_kind = 1; mode_in = 3; next_in = 5'd20; lim_in = 5'd10; amix_in = 0; measure(1);
    chk("R8 auto rising slow", c_slow, P - B - F - 1);
    next_in = 5'd3; measure(1);
    chk("R8 auto falling fast", c_fast, P - B - F - 1);
    amix_in = 1; measure(1);
    chk("R8 auto falling mixed", c_fast, ((P - B - F) >> SH) - 1);

    mode_in = 0; sr_in = 3; measure(1);
    chk("R10 on after long dead time", c_on, B + F - 8 * DTB);
    chk("R10 common switch gap", c_lsb, 16 * DTB);

    cmp_kind = 0; sr_in = 1; measure(1);
    pol_in = 0;
    c_zero = 0;
    for (int i = 0; i < 2 * P; i++) begin
      @(negedge clk);
      if ({hs_b, ls_b, hs_a, ls_a} == 4'b0000) c_zero++;
    end
    chk("R12 polarity gap", c_zero, 2 * DTB);
    chk("R2 on pattern pol0", int'({hs_b, ls_b, hs_a, ls_a}), 9);

    while (m_cnt != 5) @(negedge clk);
    lim_in = 5'd21;
    @(negedge clk);
    chk("R9 limit held mid period", int'(lim_out), 10);
    while (m_cnt != 0) @(negedge clk);
    chk("R9 limit at boundary", int'(lim_out), 21);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule